// File: doc/BRIEF.md
# Power Amplifier Ramp Sequencer

This block produces the control codes that shape a transmitter power amplifier's output at the edges of a burst. It drives two codes. A 5-bit shape code goes to a shape converter. An 8-bit peak-level code goes to a second converter. The peak level is programmed on its own and is not tied to the shape.

A ramp is started with a rise or a fall command. The block then walks one of two programmable 64-entry shape tables, one step per step period. The step period is 3 clocks (fast rate) or 6 clocks (slow rate). With a 13 MHz clock and 48 clocks per bit, these equal one sixteenth and one eighth of a bit.

While no ramp is running, the shape code rests on the current table position. The tables, the peak level and the rate are loaded through a plain write port. The burst controller that decides when to ramp sees a busy flag, and a one-cycle done pulse at the end of every fall.

Top module: `pa_ramp_seq`

## Requirements
- R1: After reset, shape_code is rising-table entry 0, level_code is 0, busy and done are 0, and the slow rate is selected.
- R2: After reset, rising entry i holds floor(31*(189*i*i - 2*i*i*i)/250047), and falling entry i holds 31 minus rising entry i.
- R3: A rise command accepted at a clock edge makes shape_code show rising entries 0 through 63 in turn, one step period each. busy is 1 for all 64 step periods and drops at the edge that ends step 63.
- R4: The step period is 6 clocks when the rate bit is 0 (slow) and 3 clocks when it is 1 (fast).
- R5: When a rise completes, shape_code holds rising entry 63 and busy is 0, until the next command.
- R6: A fall command walks falling entries 0 through 63 with the same timing. Afterwards shape_code holds falling entry 63, busy is 0, and done is 1 for exactly the first cycle after the ramp ends.
- R7: A rise or fall command that arrives while busy is 1 is ignored, and the running ramp continues unchanged.
- R8: A table write (tbl_sel 0 selects rising, 1 selects falling; tbl_addr selects the entry, tbl_data is the value) takes effect in the next cycle, including on a held output.
- R9: A level write changes level_code in the next cycle when busy is 0. It is ignored when busy is 1.
- R10: A rate write (rate_fast) is accepted only when busy is 0. It is ignored during a ramp.
- R11: If rise and fall commands arrive together while busy is 0, the rise wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_up | input | 1 | Rise command, one cycle |
| start_down | input | 1 | Fall command, one cycle |
| tbl_we | input | 1 | Shape table write strobe |
| tbl_sel | input | 1 | Table select: 0 rising, 1 falling |
| tbl_addr | input | 6 | Table entry |
| tbl_data | input | 5 | Table value |
| lvl_we | input | 1 | Peak level write strobe |
| lvl_data | input | 8 | Peak level value |
| rate_we | input | 1 | Rate write strobe |
| rate_fast | input | 1 | 1 fast (3 clocks/step), 0 slow (6 clocks/step) |
| shape_code | output | 5 | Shape converter code |
| level_code | output | 8 | Peak level converter code |
| busy | output | 1 | Ramp in progress |
| done | output | 1 | One-cycle pulse at the end of a fall |

## Verification
The assertions assume that the level and rate registers change only between ramps. They also assume that the step position moves only on a step tick, so any command or write issued mid-ramp must leave the sequence untouched. They further assume that the step timer's count never reaches the selected step period.

The stimulus drives every command as a single-cycle pulse, shortly after a clock edge. It injects commands, level writes and rate writes in the middle of a ramp, so that these assumptions are exercised rather than avoided. The sequence of expected shape codes is derived from the default-table formula and from the table writes the bench has made.

// File: rtl/pa_ramp_pkg.sv
package pa_ramp_pkg;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_RISE = 2'd1,
      PH_FALL = 2'd2
   } ramp_phase_t;

   // Smoothstep profile scaled to the code range; descending variant mirrors it.
   function automatic int unsigned default_shape(input int unsigned idx,
                                                 input int unsigned depth,
                                                 input int unsigned width,
                                                 input bit descend);
      longint unsigned top;
      longint unsigned n;
      longint unsigned i;
      longint unsigned v;
      top = (64'd1 << width) - 64'd1;
      n   = longint'(depth) - 64'd1;
      i   = longint'(idx);
      v   = (top * (3 * n * i * i - 2 * i * i * i)) / (n * n * n);
      return descend ? int'(top - v) : int'(v);
   endfunction

endpackage

// File: rtl/pa_ramp_table.sv
module pa_ramp_table #(
   parameter int DEPTH   = 64,
   parameter int WIDTH   = 5,
   parameter bit DESCEND = 1'b0,
   localparam int AW     = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [AW-1:0]    waddr,
   input  logic [WIDTH-1:0] wdata,
   input  logic [AW-1:0]    raddr,
   output logic [WIDTH-1:0] rdata
);

   logic [WIDTH-1:0] mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++)
            mem[i] <= WIDTH'(pa_ramp_pkg::default_shape(i, DEPTH, WIDTH, DESCEND));
      end else if (we) begin
         mem[waddr] <= wdata;
      end
   end

   assign rdata = mem[raddr];

   // R8: a write reaches the read port one cycle later
   assert_write_lands_R8: assert property (@(posedge clk) disable iff (!rst_n)
      we && (waddr == raddr) |=> (rdata == $past(wdata)) || (raddr != $past(raddr)));

endmodule

// File: rtl/pa_ramp_timer.sv
module pa_ramp_timer #(
   parameter int FAST_CLKS = 3,
   parameter int SLOW_CLKS = 6,
   localparam int MAXC     = (SLOW_CLKS > FAST_CLKS) ? SLOW_CLKS : FAST_CLKS,
   localparam int CW       = $clog2(MAXC + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic slow,
   output logic tick
);

   logic [CW-1:0] cnt;
   logic [CW-1:0] limit;

   generate
      if (FAST_CLKS == SLOW_CLKS) begin : g_single_rate
         assign limit = CW'(FAST_CLKS);
      end else begin : g_dual_rate
         assign limit = slow ? CW'(SLOW_CLKS) : CW'(FAST_CLKS);
      end
   endgenerate

   assign tick = run && (cnt == limit - CW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (!run) cnt <= '0;
      else if (tick) cnt <= '0;
      else           cnt <= cnt + CW'(1);
   end

   // R4: the step count never reaches the selected step period
   assert_count_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> cnt < limit);

endmodule

// File: rtl/pa_ramp_seq.sv
module pa_ramp_seq #(
   parameter int STEPS     = 64,
   parameter int SHAPE_W   = 5,
   parameter int LEVEL_W   = 8,
   parameter int FAST_CLKS = 3,
   parameter int SLOW_CLKS = 6,
   localparam int IDX_W    = $clog2(STEPS)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_up,
   input  logic               start_down,
   input  logic               tbl_we,
   input  logic               tbl_sel,
   input  logic [IDX_W-1:0]   tbl_addr,
   input  logic [SHAPE_W-1:0] tbl_data,
   input  logic               lvl_we,
   input  logic [LEVEL_W-1:0] lvl_data,
   input  logic               rate_we,
   input  logic               rate_fast,
   output logic [SHAPE_W-1:0] shape_code,
   output logic [LEVEL_W-1:0] level_code,
   output logic               busy,
   output logic               done
);
   import pa_ramp_pkg::*;

   localparam logic [IDX_W-1:0] LAST = IDX_W'(STEPS - 1);

   generate
      if (STEPS < 2 || (1 << IDX_W) != STEPS) begin : g_bad_steps
         $error("STEPS must be a power of two of at least 2");
      end
      if (FAST_CLKS < 2 || SLOW_CLKS < 2) begin : g_bad_rate
         $error("step periods must be at least 2 clocks");
      end
   endgenerate

   ramp_phase_t        phase;
   logic [IDX_W-1:0]   step_idx;
   logic               on_fall;
   logic [LEVEL_W-1:0] level_q;
   logic               slow_q;
   logic               done_q;
   logic               tick;
   logic [SHAPE_W-1:0] rise_rd;
   logic [SHAPE_W-1:0] fall_rd;

   assign busy = (phase != PH_IDLE);

   pa_ramp_timer #(.FAST_CLKS(FAST_CLKS), .SLOW_CLKS(SLOW_CLKS)) u_timer (
      .clk(clk), .rst_n(rst_n), .run(busy), .slow(slow_q), .tick(tick)
   );

   pa_ramp_table #(.DEPTH(STEPS), .WIDTH(SHAPE_W), .DESCEND(1'b0)) u_rise_tbl (
      .clk(clk), .rst_n(rst_n), .we(tbl_we && !tbl_sel), .waddr(tbl_addr),
      .wdata(tbl_data), .raddr(step_idx), .rdata(rise_rd)
   );

   pa_ramp_table #(.DEPTH(STEPS), .WIDTH(SHAPE_W), .DESCEND(1'b1)) u_fall_tbl (
      .clk(clk), .rst_n(rst_n), .we(tbl_we && tbl_sel), .waddr(tbl_addr),
      .wdata(tbl_data), .raddr(step_idx), .rdata(fall_rd)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase    <= PH_IDLE;
         step_idx <= '0;
         on_fall  <= 1'b0;
         done_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (!busy) begin
            if (start_up) begin
               phase    <= PH_RISE;
               step_idx <= '0;
               on_fall  <= 1'b0;
            end else if (start_down) begin
               phase    <= PH_FALL;
               step_idx <= '0;
               on_fall  <= 1'b1;
            end
         end else if (tick) begin
            if (step_idx == LAST) begin
               phase  <= PH_IDLE;
               done_q <= on_fall;
            end else begin
               step_idx <= step_idx + IDX_W'(1);
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level_q <= '0;
         slow_q  <= 1'b1;
      end else if (!busy) begin
         if (lvl_we)  level_q <= lvl_data;
         if (rate_we) slow_q  <= !rate_fast;
      end
   end

   assign shape_code = on_fall ? fall_rd : rise_rd;
   assign level_code = level_q;
   assign done       = done_q;

   // R9: level cannot move during a ramp
   assert_level_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
      busy && lvl_we |=> $stable(level_code));

   // R10: rate cannot move during a ramp
   assert_rate_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
      busy && rate_we |=> $stable(slow_q));

   // R7: between ticks the position and table choice are untouched by commands
   assert_ignore_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !tick |=> $stable(step_idx) && $stable(on_fall));

   // R3: within a ramp the position never goes backwards
   assert_monotonic_R3: assert property (@(posedge clk) disable iff (!rst_n)
      busy && $past(busy) |-> step_idx >= $past(step_idx));

   // R6: done only appears at the end of a completed fall
   assert_done_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy && on_fall && (step_idx == LAST) && $past(busy));

endmodule

// File: tb/pa_ramp_seq_bench.sv
module pa_ramp_seq_bench;

   typedef struct {
      logic [4:0] shape;
      logic       busy;
      logic       done;
      string      tag;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_up = 1'b0, start_down = 1'b0;
   logic       tbl_we = 1'b0, tbl_sel = 1'b0;
   logic [5:0] tbl_addr = '0;
   logic [4:0] tbl_data = '0;
   logic       lvl_we = 1'b0;
   logic [7:0] lvl_data = '0;
   logic       rate_we = 1'b0, rate_fast = 1'b0;
   logic [4:0] shape_code;
   logic [7:0] level_code;
   logic       busy, done;

   int   n_checks = 0;
   int   n_fail = 0;
   int   cycles = 0;
   exp_t q[$];
   int   rise_m[64];
   int   fall_m[64];
   bit   slow_m = 1'b1;
   logic [7:0] level_m = '0;

   always #4 clk = ~clk;

   pa_ramp_seq u_pa_ramp_seq (
      .clk(clk), .rst_n(rst_n), .start_up(start_up), .start_down(start_down),
      .tbl_we(tbl_we), .tbl_sel(tbl_sel), .tbl_addr(tbl_addr), .tbl_data(tbl_data),
      .lvl_we(lvl_we), .lvl_data(lvl_data), .rate_we(rate_we), .rate_fast(rate_fast),
      .shape_code(shape_code), .level_code(level_code), .busy(busy), .done(done)
   );

   task automatic summary();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   endtask

   task automatic chk(input bit ok, input string tag, input int act, input int expv);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
         summary();
      end
   end

   // Monitor: pops one expected item per cycle, between edges
   always @(negedge clk) begin
      if (q.size() != 0) begin
         exp_t e;
         e = q.pop_front();
         chk(shape_code == e.shape, {e.tag, " shape"}, shape_code, e.shape);
         chk(busy == e.busy, {e.tag, " busy"}, busy, e.busy);
         chk(done == e.done, {e.tag, " done"}, done, e.done);
      end
   end

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic tbl_write(input bit sel, input int addr, input int val);
      tick();
      tbl_we = 1'b1; tbl_sel = sel; tbl_addr = 6'(addr); tbl_data = 5'(val);
      tick();
      tbl_we = 1'b0;
      if (sel) fall_m[addr] = val; else rise_m[addr] = val;
   endtask

   // Driver: issues commands and pushes the expected per-cycle sequence
   task automatic run_ramp(input bit up, input bit down, input bit meddle, input string tag);
      int  n;
      bit  fall;
      exp_t e;
      n = slow_m ? 6 : 3;
      fall = !up;
      tick();
      start_up = up; start_down = down;
      tick();
      start_up = 1'b0; start_down = 1'b0;
      for (int k = 0; k < 64; k++) begin
         for (int c = 0; c < n; c++) begin
            e.shape = 5'(fall ? fall_m[k] : rise_m[k]);
            e.busy = 1'b1; e.done = 1'b0; e.tag = tag;
            q.push_back(e);
         end
      end
      e.shape = 5'(fall ? fall_m[63] : rise_m[63]);
      e.busy = 1'b0; e.done = fall; e.tag = {tag, " end"};
      q.push_back(e);
      if (meddle) begin
         repeat (29) @(posedge clk);
         #1;
         // R7 R9 R10: commands and writes during the ramp
         start_up = 1'b1; start_down = 1'b1;
         lvl_we = 1'b1; lvl_data = 8'hAA;
         rate_we = 1'b1; rate_fast = slow_m;
         tick();
         start_up = 1'b0; start_down = 1'b0; lvl_we = 1'b0; rate_we = 1'b0;
      end
      while (q.size() != 0) @(posedge clk);
   endtask

   initial begin
      for (int i = 0; i < 64; i++) begin
         rise_m[i] = (31 * (189 * i * i - 2 * i * i * i)) / 250047;
         fall_m[i] = 31 - rise_m[i];
      end
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk(shape_code == 5'(rise_m[0]), "R1 shape", shape_code, rise_m[0]);
      chk(level_code == 8'd0, "R1 level", level_code, 0);
      chk(busy == 1'b0, "R1 busy", busy, 0);
      chk(done == 1'b0, "R1 done", done, 0);

      // R3 R2 R4 (slow default) R7 R9 R10: rise with interference
      run_ramp(1'b1, 1'b0, 1'b1, "R3 R2 R4 R7 rise slow");
      @(negedge clk);
      chk(shape_code == 5'(rise_m[63]), "R5 hold", shape_code, rise_m[63]);
      chk(busy == 1'b0, "R5 busy", busy, 0);
      chk(level_code == level_m, "R9 ignored while busy", level_code, level_m);

      // R9: level write when idle
      tick();
      lvl_we = 1'b1; lvl_data = 8'h5C; level_m = 8'h5C;
      tick();
      lvl_we = 1'b0;
      @(negedge clk);
      chk(level_code == level_m, "R9 idle write", level_code, level_m);
      chk(shape_code == 5'(rise_m[63]), "R5 still held", shape_code, rise_m[63]);

      // R8: falling table edits, then R6 fall still slow (R10 ignored earlier)
      tbl_write(1'b1, 10, 3);
      tbl_write(1'b1, 40, 17);
      run_ramp(1'b0, 1'b1, 1'b0, "R6 R8 R10 fall slow");
      @(negedge clk);
      chk(done == 1'b0, "R6 done one cycle", done, 0);
      chk(shape_code == 5'(fall_m[63]), "R6 hold", shape_code, fall_m[63]);

      // R8: write to the held entry shows next cycle
      tbl_write(1'b1, 63, 9);
      @(negedge clk);
      chk(shape_code == 5'd9, "R8 held entry", shape_code, 9);

      // R4 R10: fast rate, R11: both commands together
      tick();
      rate_we = 1'b1; rate_fast = 1'b1; slow_m = 1'b0;
      tick();
      rate_we = 1'b0;
      tbl_write(1'b0, 5, 30);
      run_ramp(1'b1, 1'b1, 1'b0, "R11 R4 R8 rise fast");
      run_ramp(1'b0, 1'b1, 1'b0, "R6 R4 fall fast");
      @(negedge clk);
      chk(level_code == level_m, "R9 level kept", level_code, level_m);
      summary();
   end

endmodule